// File: doc/BRIEF.md
# Downlink Envelope Command Receiver

This block listens to the reader-to-tag direction of a passive 125 kHz tag. On each RF carrier tick it receives one bit of field strength from the analog peak detector: high field, or low field while the reader modulates. In read mode it watches for the reader's synchronisation envelope. That envelope is a run of high samples, then at least one low sample, then a high sample again. When the envelope is seen, the block takes control of the tag's modulator load. It then hunts for a start bit by oversampling at one eighth of a bit period.

Once a start bit is found, the block clocks in an NRZ command byte, most significant bit first. A write opcode is followed by three more framed bytes. The block reports each recognised command as a one-cycle pulse carrying a command kind, the first byte and a 24-bit payload.

While the block receives, it toggles the load within every bit so the tag keeps its supply. Time-outs are applied at each stage. After power-up, after a reset command and after a failed first start-bit search, envelope detection is blocked for one full readout cycle. CRC checking, protection checking, the power check and the EEPROM write happen outside the block. The outside logic reports back with `ack_end` when the write acknowledge has ended, or with `wr_abort` when the write is refused.

Top module: `dlcmd_rx`

## Requirements
- R1: After reset the receiver is in its blocked phase: `rx_own`, `rx_load` and `cmd_valid` are 0.
- R2: In read mode the field is sampled once per bit period (`BIT_TICKS` ticks). Start-bit search begins when two conditions are met in order. First, at least 4 consecutive high samples are followed by a low sample. Second, a later sample is high. A low sample before 4 highs restarts the count. On entering search, `rx_own` and `rx_load` both go to 1.
- R3: During start-bit search the field is sampled every `BIT_TICKS/8` ticks, and three consecutive low samples start reception. When search follows the envelope and no start bit arrives within 8 bit periods, the receiver enters the blocked phase.
- R4: During reception each bit window lasts one bit period. The load is off for the first half of the window and on for the second half. The bit value is the field sample on the last tick of the window, with high meaning 1 and low meaning 0, and bits arrive most significant first.
- R5: Three single-byte commands are recognised. Each gives a one-cycle `cmd_valid` with `cmd_head` holding the received byte and a zero payload:
  - 8'hA0 is reset, kind 1, and leads to the blocked phase.
  - 8'hA5 is read ROM, kind 2, and leads to read mode.
  - 8'hF0 is read configuration, kind 5, and leads to read mode.
  
  Any byte that is not a recognised opcode gives no pulse and returns to read mode with no blocked phase.
- R6: Two first bytes start a write frame:
  - A first byte with upper nibble 4'hC starts a word write, kind 3.
  - 8'hD3 starts a configuration write, kind 4.
  
  Three further bytes are then received. One pulse reports the first byte in `cmd_head` and the three bytes in `cmd_payload`, earliest byte in bits 23:16. `rx_own` drops with the pulse.
- R7: Between the bytes of a write frame, the load is off for half a bit period. Start-bit search then runs with a 2-bit-period time-out. On that time-out the receiver returns to read mode with no pulse and no blocked phase.
- R8: The blocked phase lasts `READOUT_BITS` bit periods. During it no envelope is detected and `rx_own` stays 0.
- R9: After a write pulse the receiver waits. `ack_end` starts a start-bit search with a 2-bit-period time-out, which allows back-to-back write frames without a new envelope. If that search times out, the receiver returns to read mode with no blocked phase. `wr_abort` returns the receiver to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| rf_tick | input | 1 | One-cycle enable per RF carrier period |
| field_hi | input | 1 | Peak-detector result, 1 = high field |
| ack_end | input | 1 | Write acknowledge finished, resume start-bit search |
| wr_abort | input | 1 | Write refused, return to read mode |
| rx_own | output | 1 | Receiver controls the modulator load |
| rx_load | output | 1 | Modulator load on request while `rx_own` |
| cmd_valid | output | 1 | One-cycle decoded-command pulse |
| cmd_kind | output | 3 | 1 reset, 2 read ROM, 3 word write, 4 config write, 5 read config |
| cmd_head | output | 8 | First command byte |
| cmd_payload | output | 24 | Bytes two to four of a write frame, else 0 |

## Verification
The hardest situation to reach is the chained write. The receiver sits idle after a write pulse and must accept a second four-byte frame with no new envelope. Each inter-byte search must then land inside its short 2-bit window. The stimulus reaches it by starting every start bit on the first half-cycle after search is entered. The acknowledge is pulsed right after the first frame's stop bit, and a second frame is sent straight away. The blocked phases are tested by sending envelope-like patterns inside them; a receiver that skipped the blocked phase would detect those patterns.

// File: rtl/dlcmd_rx.sv
module dlcmd_rx #(
  parameter int BIT_TICKS    = 64,
  parameter int READOUT_BITS = 128,
  parameter int SYNC_HIGHS   = 4,
  parameter int START_LOWS   = 3,
  parameter int LONG_BITS    = 8,
  parameter int SHORT_BITS   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rf_tick,
  input  logic        field_hi,
  input  logic        ack_end,
  input  logic        wr_abort,
  output logic        rx_own,
  output logic        rx_load,
  output logic        cmd_valid,
  output logic [2:0]  cmd_kind,
  output logic [7:0]  cmd_head,
  output logic [23:0] cmd_payload
);
  localparam int SUB     = BIT_TICKS / 8;
  localparam int HALF    = BIT_TICKS / 2;
  localparam int LONG_T  = LONG_BITS * BIT_TICKS;
  localparam int SHORT_T = SHORT_BITS * BIT_TICKS;
  localparam int TW      = $clog2(LONG_T + 1);
  localparam int BW      = $clog2(READOUT_BITS + 8);
  localparam int SW      = $clog2(SUB + 1);
  localparam int HW      = $clog2(SYNC_HIGHS + 1);
  localparam int LW      = $clog2(START_LOWS + 1);

  localparam logic [2:0] K_RST = 3'd1, K_ROM = 3'd2, K_WRW = 3'd3, K_WRC = 3'd4, K_RCF = 3'd5;

  typedef enum logic [2:0] {S_BLANK, S_READ, S_SEARCH, S_RX, S_GAP, S_WAIT} st_t;

  st_t          st;
  logic [TW-1:0] tcnt;
  logic [BW-1:0] bcnt;
  logic [SW-1:0] scnt;
  logic [HW-1:0] hcnt;
  logic [LW-1:0] lcnt;
  logic          ph, long_to;
  logic [1:0]    byte_idx;
  logic [7:0]    sh, head;
  logic [23:0]   pay;

  logic       bit_end, sub_end, to_hit, is_write;
  logic [7:0] byte_v;

  assign bit_end  = tcnt == TW'(BIT_TICKS - 1);
  assign sub_end  = scnt == SW'(SUB - 1);
  assign to_hit   = tcnt == (long_to ? TW'(LONG_T - 1) : TW'(SHORT_T - 1));
  assign byte_v   = {sh[6:0], field_hi};
  assign is_write = (byte_v == 8'hD3) || (byte_v[7:4] == 4'hC);

  assign rx_own  = (st == S_SEARCH) || (st == S_RX) || (st == S_GAP);
  assign rx_load = (st == S_SEARCH) || ((st == S_RX) && (tcnt >= TW'(HALF)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_BLANK;
      tcnt        <= '0;
      bcnt        <= '0;
      scnt        <= '0;
      hcnt        <= '0;
      lcnt        <= '0;
      ph          <= 1'b0;
      long_to     <= 1'b0;
      byte_idx    <= '0;
      sh          <= '0;
      head        <= '0;
      pay         <= '0;
      cmd_valid   <= 1'b0;
      cmd_kind    <= '0;
      cmd_head    <= '0;
      cmd_payload <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (st == S_WAIT) begin
        if (ack_end) begin
          st      <= S_SEARCH;
          long_to <= 1'b0;
          tcnt    <= '0;
          scnt    <= '0;
          lcnt    <= '0;
        end else if (wr_abort) begin
          st   <= S_READ;
          tcnt <= '0;
          ph   <= 1'b0;
          hcnt <= '0;
        end
      end else if (rf_tick) begin
        tcnt <= tcnt + 1'b1;
        case (st)
          S_BLANK: if (bit_end) begin
            tcnt <= '0;
            bcnt <= bcnt + 1'b1;
            if (bcnt == BW'(READOUT_BITS - 1)) begin
              st   <= S_READ;
              bcnt <= '0;
              ph   <= 1'b0;
              hcnt <= '0;
            end
          end
          S_READ: if (bit_end) begin
            tcnt <= '0;
            if (!ph) begin
              if (field_hi) begin
                if (hcnt != HW'(SYNC_HIGHS)) hcnt <= hcnt + 1'b1;
              end else if (hcnt == HW'(SYNC_HIGHS)) ph <= 1'b1;
              else hcnt <= '0;
            end else if (field_hi) begin
              st       <= S_SEARCH;
              long_to  <= 1'b1;
              scnt     <= '0;
              lcnt     <= '0;
              byte_idx <= '0;
            end
          end
          S_SEARCH: begin
            scnt <= sub_end ? '0 : scnt + 1'b1;
            if (sub_end && !field_hi && lcnt == LW'(START_LOWS - 1)) begin
              st   <= S_RX;
              tcnt <= '0;
              bcnt <= '0;
            end else begin
              if (sub_end) lcnt <= field_hi ? '0 : lcnt + 1'b1;
              if (to_hit) begin
                st   <= long_to ? S_BLANK : S_READ;
                tcnt <= '0;
                bcnt <= '0;
                ph   <= 1'b0;
                hcnt <= '0;
              end
            end
          end
          S_RX: if (bit_end) begin
            tcnt <= '0;
            sh   <= byte_v;
            bcnt <= bcnt + 1'b1;
            if (bcnt == BW'(7)) begin
              bcnt <= '0;
              ph   <= 1'b0;
              hcnt <= '0;
              if (byte_idx == 2'd0) begin
                head <= byte_v;
                pay  <= '0;
                if (byte_v == 8'hA0 || byte_v == 8'hA5 || byte_v == 8'hF0) begin
                  cmd_valid   <= 1'b1;
                  cmd_head    <= byte_v;
                  cmd_payload <= '0;
                  cmd_kind    <= (byte_v == 8'hA0) ? K_RST : (byte_v == 8'hA5) ? K_ROM : K_RCF;
                  st          <= (byte_v == 8'hA0) ? S_BLANK : S_READ;
                end else if (is_write) begin
                  byte_idx <= 2'd1;
                  st       <= S_GAP;
                end else begin
                  st <= S_READ;
                end
              end else begin
                pay <= {pay[15:0], byte_v};
                if (byte_idx == 2'd3) begin
                  cmd_valid   <= 1'b1;
                  cmd_head    <= head;
                  cmd_payload <= {pay[15:0], byte_v};
                  cmd_kind    <= (head == 8'hD3) ? K_WRC : K_WRW;
                  byte_idx    <= 2'd0;
                  st          <= S_WAIT;
                end else begin
                  byte_idx <= byte_idx + 1'b1;
                  st       <= S_GAP;
                end
              end
            end
          end
          S_GAP: if (tcnt == TW'(HALF - 1)) begin
            st      <= S_SEARCH;
            tcnt    <= '0;
            scnt    <= '0;
            lcnt    <= '0;
            long_to <= 1'b0;
          end
          default: st <= S_READ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dlcmd_rx_chk.sv
module dlcmd_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_own,
  input logic        rx_load,
  input logic        cmd_valid,
  input logic [2:0]  cmd_kind,
  input logic [23:0] cmd_payload
);
  AST_LOAD_NEEDS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |-> rx_own); // R4
  AST_SEARCH_STARTS_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_own) |-> rx_load); // R2
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R5
  AST_PULSE_HAS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_kind >= 3'd1 && cmd_kind <= 3'd5)); // R5
  AST_SHORT_CMD_NO_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_kind == 3'd1 || cmd_kind == 3'd2 || cmd_kind == 3'd5)) |-> cmd_payload == 24'd0); // R5
  AST_RELEASE_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !rx_own); // R6
endmodule

bind dlcmd_rx dlcmd_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_own(rx_own), .rx_load(rx_load),
  .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_payload(cmd_payload)
);

// File: tb/sim_dlcmd_rx.sv
module sim_dlcmd_rx;
  localparam int BT      = 16;
  localparam int RB      = 8;
  localparam int SUB     = BT / 8;
  localparam int HALF    = BT / 2;
  localparam int LONG_T  = 8 * BT;
  localparam int SHORT_T = 2 * BT;

  logic clk = 1'b0;
  logic rst_n, rf_tick, field_hi, ack_end, wr_abort;
  logic rx_own, rx_load, cmd_valid;
  logic [2:0] cmd_kind;
  logic [7:0] cmd_head;
  logic [23:0] cmd_payload;

  always #4 clk = ~clk;

  dlcmd_rx #(.BIT_TICKS(BT), .READOUT_BITS(RB)) u0 (
    .clk(clk), .rst_n(rst_n), .rf_tick(rf_tick), .field_hi(field_hi),
    .ack_end(ack_end), .wr_abort(wr_abort), .rx_own(rx_own), .rx_load(rx_load),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_head(cmd_head), .cmd_payload(cmd_payload)
  );

  int vecs = 0, fails = 0, npulse = 0;
  bit done = 0, own_seen = 0;
  logic [2:0] last_kind;
  logic [7:0] last_head;
  logic [23:0] last_pay;

  // behavioural reference model
  logic m_own = 0, m_load = 0, m_valid = 0;
  logic [2:0] m_kind = 0;
  logic [7:0] m_head = 0;
  logic [23:0] m_pay = 0;
  string mreq = "R1";
  int mode = 0;

  task automatic step();
    @(posedge clk);
    m_valid = 1'b0;
  endtask

  task automatic emit(input logic [2:0] k, input logic [7:0] h, input logic [23:0] p);
    m_valid = 1'b1; m_kind = k; m_head = h; m_pay = p; m_own = 0; m_load = 0;
  endtask

  task automatic do_search(input int lim, output bit got);
    int lows = 0;
    got = 0; m_own = 1; m_load = 1; mreq = "R3";
    for (int j = 1; j <= lim; j++) begin
      step();
      if (j % SUB == 0) begin
        if (!field_hi) lows++; else lows = 0;
        if (lows == 3) begin got = 1; break; end
      end
    end
    if (!got) begin m_own = 0; m_load = 0; end
  endtask

  task automatic rxbyte(output logic [7:0] v);
    v = 8'h00; m_own = 1; m_load = 0; mreq = "R4";
    for (int i = 0; i < 8; i++)
      for (int j = 1; j <= BT; j++) begin
        step();
        if (j < BT) m_load = (j >= HALF);
        else begin v = {v[6:0], field_hi}; m_load = 0; end
      end
  endtask

  task automatic handle_cmd();
    logic [7:0] b0, bk;
    logic [23:0] p;
    bit got;
    rxbyte(b0);
    mreq = "R5";
    if (b0 == 8'hA0) begin emit(3'd1, b0, 0); mode = 0; end
    else if (b0 == 8'hA5) begin emit(3'd2, b0, 0); mode = 1; end
    else if (b0 == 8'hF0) begin emit(3'd5, b0, 0); mode = 1; end
    else if (b0 == 8'hD3 || b0[7:4] == 4'hC) begin
      p = 0;
      for (int k = 1; k <= 3; k++) begin
        m_load = 0; mreq = "R7";
        repeat (HALF) step();
        do_search(SHORT_T, got);
        if (!got) begin mode = 1; return; end
        rxbyte(bk);
        p = {p[15:0], bk};
      end
      mreq = "R6";
      emit((b0 == 8'hD3) ? 3'd4 : 3'd3, b0, p);
      mode = 2;
    end else begin
      m_own = 0; m_load = 0; mode = 1;
    end
  endtask

  initial begin
    int hi;
    bit lowseen, got;
    wait (rst_n === 1'b1);
    mode = 0;
    forever begin
      if (mode == 0) begin
        mreq = "R8"; m_own = 0; m_load = 0;
        repeat (RB * BT) step();
        mode = 1;
      end else if (mode == 1) begin
        mreq = "R2"; m_own = 0; m_load = 0; hi = 0; lowseen = 0;
        forever begin
          repeat (BT) step();
          if (!lowseen) begin
            if (field_hi) begin if (hi < 4) hi++; end
            else if (hi >= 4) lowseen = 1;
            else hi = 0;
          end else if (field_hi) break;
        end
        do_search(LONG_T, got);
        if (!got) mode = 0; else handle_cmd();
      end else begin
        mreq = "R9"; m_own = 0; m_load = 0;
        forever begin
          step();
          if (ack_end) begin
            do_search(SHORT_T, got);
            if (!got) mode = 1; else handle_cmd();
            break;
          end else if (wr_abort) begin
            mode = 1;
            break;
          end
        end
      end
    end
  end

  // per-clock comparison and port monitor
  always @(negedge clk) if (rst_n === 1'b1 && !done) begin
    vecs++;
    if (rx_own !== m_own || rx_load !== m_load || cmd_valid !== m_valid ||
        (m_valid && (cmd_kind !== m_kind || cmd_head !== m_head || cmd_payload !== m_pay))) begin
      fails++;
      $display("FAIL %s t=%0t own/load/valid/kind/head/pay actual=%b%b%b %0d %h %h expected=%b%b%b %0d %h %h",
               mreq, $time, rx_own, rx_load, cmd_valid, cmd_kind, cmd_head, cmd_payload,
               m_own, m_load, m_valid, m_kind, m_head, m_pay);
    end
    if (rx_own) own_seen = 1;
    if (cmd_valid) begin npulse++; last_kind = cmd_kind; last_head = cmd_head; last_pay = cmd_payload; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold(input logic lv, input int n);
    field_hi = lv;
    repeat (n) @(negedge clk);
  endtask

  task automatic sync();
    hold(1, 6 * BT);
    hold(0, 3 * BT);
    field_hi = 1;
    wait (m_own === 1'b1);
    @(negedge clk);
  endtask

  task automatic sendbyte(input logic [7:0] b);
    hold(0, BT);
    for (int i = 7; i >= 0; i--) hold(b[i], BT);
    hold(1, BT);
  endtask

  task automatic pulse_ack();
    ack_end = 1; @(negedge clk); ack_end = 0;
  endtask

  initial begin
    int np;
    rst_n = 0; rf_tick = 1; field_hi = 1; ack_end = 0; wr_abort = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 own", rx_own, 0);
    chk("R1 valid", cmd_valid, 0);
    // envelope inside the power-up blocked phase
    own_seen = 0;
    hold(1, 4 * BT); hold(0, BT); hold(1, 2 * BT);
    chk("R8 blocked after reset", own_seen, 0);
    hold(1, 2 * BT);
    // read ROM
    sync(); sendbyte(8'hA5); hold(1, 2 * BT);
    chk("R5 rom kind", last_kind, 3'd2);
    chk("R4 msb-first head", last_head, 8'hA5);
    // too few highs before the low
    own_seen = 0;
    hold(0, 3 * BT); hold(1, 3 * BT); hold(0, 3 * BT); hold(1, 2 * BT);
    chk("R2 short run ignored", own_seen, 0);
    // unknown byte, then immediate re-sync without blocking
    np = npulse;
    sync(); sendbyte(8'h55);
    chk("R5 unknown no pulse", npulse, np);
    sync(); sendbyte(8'hF0); hold(1, BT);
    chk("R5 rcfg kind", last_kind, 3'd5);
    // write word, ack, back-to-back config write
    sync();
    sendbyte(8'hC5); sendbyte(8'hD2); sendbyte(8'h2D); sendbyte(8'h20);
    chk("R6 wr kind", last_kind, 3'd3);
    chk("R6 wr head", last_head, 8'hC5);
    chk("R6 wr payload", last_pay, 24'hD22D20);
    pulse_ack();
    sendbyte(8'hD3); sendbyte(8'h02); sendbyte(8'h55); sendbyte(8'h2F);
    chk("R9 chained kind", last_kind, 3'd4);
    chk("R9 chained payload", last_pay, 24'h02552F);
    pulse_ack();
    hold(1, 3 * BT);
    chk("R9 ack timeout releases", rx_own, 0);
    // inter-byte timeout
    np = npulse;
    sync(); sendbyte(8'hC1); hold(1, 3 * BT);
    chk("R7 gap timeout no pulse", npulse, np);
    chk("R7 gap timeout releases", rx_own, 0);
    // write refused
    sync();
    sendbyte(8'hC7); sendbyte(8'h12); sendbyte(8'h34); sendbyte(8'h56);
    chk("R6 second payload", last_pay, 24'h123456);
    wr_abort = 1; @(negedge clk); wr_abort = 0;
    hold(1, BT);
    chk("R9 abort releases", rx_own, 0);
    // reset command and blocked phase
    sync(); sendbyte(8'hA0);
    chk("R5 reset kind", last_kind, 3'd1);
    own_seen = 0;
    hold(1, 4 * BT); hold(0, BT); hold(1, BT);
    chk("R8 blocked after reset cmd", own_seen, 0);
    hold(1, 3 * BT);
    // long start-bit time-out leads to blocked phase
    sync();
    hold(1, 15 * BT);
    own_seen = 0;
    hold(0, 2 * BT); hold(1, 2 * BT);
    chk("R3 long timeout blocks", own_seen, 0);
    hold(1, 4 * BT);
    sync(); sendbyte(8'hA5); hold(1, BT);
    chk("R3 recovers after block", last_kind, 3'd2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule